// File: doc/BRIEF.md
# Multi-Mode PWM Compare Timer

This block is one timer channel that produces a pulse-width-modulated reference level. A free-running counter steps once per clock against a programmable period limit. The counter can run upward in an edge-aligned sawtooth, downward in an edge-aligned sawtooth, or up and then down in a center-aligned triangle. A compare value is checked against the counter to set the output level. Matches between the counter and the compare value raise a sticky interrupt flag. In center-aligned operation the flag can be limited to matches on the rising slope, on the falling slope, or both.

Software sets the channel up through a small register write port. The configuration registers hold the period, the compare value, the count direction and the alignment mode. Writing the flag-clear bit acknowledges the interrupt. Writes are single-cycle strobes with no back-pressure. The register, counter and flag all update on the clock edge where the strobe is high. The output level, the counter value and the current direction are visible on plain status pins and follow the registers combinationally.

Top module: `pwm_compare_timer`

## Requirements
- R1: With mode 0 and direction bit 0, the counter steps 0,1,...,P and then returns to 0, so one period takes P+1 clocks (P is the period register).
- R2: With mode 0 and direction bit 1, the counter steps down by one each clock and reloads P on the clock after it reaches 0.
- R3: With a nonzero mode, the counter rises by one to P, then falls by one to 0, then rises again. dir_o shows 0 while rising and 1 while falling, and writes to the direction bit leave the counting unchanged.
- R4: When counting up or center-aligned, pwm_o is 1 while the counter is below the compare value C and 0 otherwise.
- R5: When counting down, pwm_o is 1 while the counter is at most C. With C = 0 the output is still 1 when the counter is 0.
- R6: Whenever C is greater than P, pwm_o is 1 on every cycle in every mode.
- R7: With mode 0, direction 0 and C = 0, pwm_o stays 0.
- R8: In mode 0, a cycle with counter equal to C sets cmp_flag_o from the next clock on. The flag then stays 1 until it is cleared.
- R9: In a nonzero mode, a match sets the flag only if the current direction is enabled. Mode 1 enables falling matches, mode 2 enables rising matches and mode 3 enables both.
- R10: A write with wr_data bit 0 set to address 3 clears the flag. If a flag-setting match occurs in the same cycle, the flag stays 1.
- R11: While rst_n is low, the counter, pwm_o, cmp_flag_o and dir_o are all 0, and all registers are 0.
- R12: The register addresses are as follows. Address 0 holds the period. Address 1 holds the compare value. Address 2 holds the direction in bit 0 and the mode in bits 2:1. Address 3 is the flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| pwm_o | output | 1 | PWM reference level |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| cnt_o | output | W | Current counter value |
| dir_o | output | 1 | Current count direction (1 = down) |

## Verification
The hardest case to reach is a flag clear that lands in the same clock as a match that should set the flag. The case is harder still in center-aligned modes, where only one slope may be enabled. The stimulus writes the clear bit on every cycle for long stretches in each mode. This makes sure that some of those writes land on a match cycle and some land on a match cycle for the disabled slope. A cycle-accurate model in the bench predicts which writes should win.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE  = 2'd0,
    CTR_FALL_IF = 2'd1,
    CTR_RISE_IF = 2'd2,
    CTR_BOTH_IF = 2'd3
  } align_e;

  localparam logic [1:0] ADR_PERIOD = 2'd0;
  localparam logic [1:0] ADR_CMP    = 2'd1;
  localparam logic [1:0] ADR_CTRL   = 2'd2;
  localparam logic [1:0] ADR_CLEAR  = 2'd3;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] per_q,
  output logic [W-1:0] cmp_q,
  output logic         dir_q,
  output align_e       mode_q,
  output logic         clr_o
);
  // R12: address decode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmp_q  <= '0;
      dir_q  <= 1'b0;
      mode_q <= ALIGN_EDGE;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_PERIOD: per_q <= wr_data;
        ADR_CMP:    cmp_q <= wr_data;
        ADR_CTRL: begin
          dir_q  <= wr_data[0];
          mode_q <= align_e'(wr_data[2:1]);
        end
        default: ;
      endcase
    end
  end

  assign clr_o = wr_en && (wr_addr == ADR_CLEAR) && wr_data[0];
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per,
  input  logic         dir_bit,
  input  align_e       mode,
  output logic [W-1:0] cnt_q,
  output logic         dir_now
);
  localparam logic [W-1:0] ONE = W'(1);

  logic slope_q;  // 0 rising, 1 falling (center mode)

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      slope_q <= 1'b0;
    end else if (mode == ALIGN_EDGE) begin
      slope_q <= dir_bit;
      if (!dir_bit) cnt_q <= (cnt_q >= per) ? '0 : cnt_q + ONE;    // R1
      else          cnt_q <= (cnt_q == '0) ? per : cnt_q - ONE;    // R2
    end else if (!slope_q) begin                                    // R3 rising
      if (cnt_q >= per) begin
        slope_q <= 1'b1;
        cnt_q   <= (cnt_q == '0) ? '0 : cnt_q - ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin                                                  // R3 falling
      if (cnt_q == '0) begin
        slope_q <= 1'b0;
        cnt_q   <= (per == '0) ? '0 : ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign dir_now = (mode == ALIGN_EDGE) ? dir_bit : slope_q;
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] per,
  input  logic [W-1:0] cmp,
  input  logic         dir_now,
  input  align_e       mode,
  output logic         pwm,
  output logic         flag_set
);
  logic edge_down, hit, slope_ok;

  always_comb begin
    edge_down = (mode == ALIGN_EDGE) && dir_now;
    // R6 saturation high, R4/R5 level rules (R7 falls out of cnt < 0)
    if (cmp > per)      pwm = 1'b1;
    else if (edge_down) pwm = (cnt <= cmp);
    else                pwm = (cnt < cmp);

    hit = (cnt == cmp);
    // R9: mode bit 0 enables falling matches, bit 1 rising matches
    slope_ok = (mode == ALIGN_EDGE) ||
               (mode[0] && dir_now) || (mode[1] && !dir_now);
    flag_set = hit && slope_ok;  // R8
  end
endmodule

// File: rtl/pwm_flag.sv
module pwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  // R10: a set in the clearing cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_i | (flag_q & ~clr_i);
  end
endmodule

// File: rtl/pwm_compare_timer.sv
module pwm_compare_timer
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_o,
  output logic         cmp_flag_o,
  output logic [W-1:0] cnt_o,
  output logic         dir_o
);
  logic [W-1:0] per_q, cmp_q;
  logic         dir_q, clr, set;
  align_e       mode_q;

  pwm_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .per_q(per_q), .cmp_q(cmp_q), .dir_q(dir_q),
    .mode_q(mode_q), .clr_o(clr)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .per(per_q), .dir_bit(dir_q),
    .mode(mode_q), .cnt_q(cnt_o), .dir_now(dir_o)
  );

  pwm_compare #(.W(W)) u_cmp (
    .cnt(cnt_o), .per(per_q), .cmp(cmp_q), .dir_now(dir_o),
    .mode(mode_q), .pwm(pwm_o), .flag_set(set)
  );

  pwm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(set), .clr_i(clr), .flag_q(cmp_flag_o)
  );
endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] per,
  input logic [W-1:0] cmp,
  input logic [1:0]   mode,
  input logic         dir_bit,
  input logic [W-1:0] cnt,
  input logic         pwm,
  input logic         flag
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == 2'd3) && wr_data[0];

  a_r1_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode == 2'd0 && !dir_bit && cnt == per) |=> (cnt == '0));

  a_r2_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode == 2'd0 && dir_bit && cnt == '0) |=> (cnt == $past(per)));

  a_r3_center_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode != 2'd0 && cnt < per) |=>
      (cnt == $past(cnt) + W'(1) || cnt + W'(1) == $past(cnt)));

  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp > per) |-> pwm);

  a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !dir_bit && cmp == '0) |-> !pwm);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_wr) |=> flag);

  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && cnt != cmp) |=> !flag);
endmodule

bind pwm_compare_timer pwm_timer_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .per(per_q), .cmp(cmp_q), .mode(mode_q),
  .dir_bit(dir_q), .cnt(cnt_o), .pwm(pwm_o), .flag(cmp_flag_o)
);

// File: tb/tb_pwm_compare_timer.sv
module tb_pwm_compare_timer;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10;

  typedef struct {
    logic [W-1:0] cnt;
    logic pwm, flag, dir;
    string tag_cnt, tag_pwm, tag_flag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic pwm_o, cmp_flag_o, dir_o;
  logic [W-1:0] cnt_o;

  int errors = 0, checks = 0;
  bit done = 0;
  exp_t q[$];

  // bench model state
  logic [W-1:0] m_cnt = '0, m_per = '0, m_cmp = '0;
  logic m_slope = 0, m_dir = 0, m_flag = 0;
  logic [1:0] m_mode = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_compare_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .cmp_flag_o(cmp_flag_o),
    .cnt_o(cnt_o), .dir_o(dir_o)
  );

  function automatic logic m_dnow();
    return (m_mode == 2'd0) ? m_dir : m_slope;
  endfunction

  function automatic logic m_pwm();
    if (m_cmp > m_per) return 1'b1;                     // R6
    if (m_mode == 2'd0 && m_dir) return m_cnt <= m_cmp; // R5
    return m_cnt < m_cmp;                               // R4, R7
  endfunction

  function automatic void chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // driver: one clock with an optional register write, model advanced, expectation queued
  task automatic tick(input logic we, input logic [1:0] a, input logic [W-1:0] d);
    logic set, clr;
    logic [W-1:0] ncnt;
    logic nslope;
    string tf;
    exp_t e;
    wr_en = we; wr_addr = a; wr_data = d;
    // flag (R8, R9, R10)
    set = (m_cnt == m_cmp) && ((m_mode == 2'd0) ||
          (m_mode[0] && m_dnow()) || (m_mode[1] && !m_dnow()));
    clr = we && a == 2'd3 && d[0];
    tf = (m_mode == 2'd0) ? "R8" : "R9";
    if (clr) tf = "R10";
    // counter (R1, R2, R3)
    ncnt = m_cnt; nslope = m_slope;
    if (m_mode == 2'd0) begin
      nslope = m_dir;
      if (!m_dir) ncnt = (m_cnt >= m_per) ? '0 : m_cnt + 1'b1;
      else        ncnt = (m_cnt == 0) ? m_per : m_cnt - 1'b1;
    end else if (!m_slope) begin
      if (m_cnt >= m_per) begin nslope = 1; ncnt = (m_cnt == 0) ? '0 : m_cnt - 1'b1; end
      else ncnt = m_cnt + 1'b1;
    end else begin
      if (m_cnt == 0) begin nslope = 0; ncnt = (m_per == 0) ? '0 : W'(1); end
      else ncnt = m_cnt - 1'b1;
    end
    @(posedge clk);
    m_flag = set | (m_flag & ~clr);
    m_cnt = ncnt; m_slope = nslope;
    if (we) begin  // R12 register map
      case (a)
        2'd0: m_per = d;
        2'd1: m_cmp = d;
        2'd2: begin m_dir = d[0]; m_mode = d[2:1]; end
        default: ;
      endcase
    end
    #1;
    e.cnt = m_cnt; e.pwm = m_pwm(); e.flag = m_flag; e.dir = m_dnow();
    e.tag_cnt = (m_mode != 0) ? "R3" : (m_dir ? "R2" : "R1");
    e.tag_pwm = (m_cmp > m_per) ? "R6" :
                (m_mode == 0 && !m_dir && m_cmp == 0) ? "R7" :
                (m_mode == 0 && m_dir) ? "R5" : "R4";
    e.tag_flag = tf;
    q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, '0);
  endtask

  task automatic run_clr(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 2'd3, W'(1));
  endtask

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag_cnt, cnt_o, e.cnt);
        chk(e.tag_pwm, W'(pwm_o), W'(e.pwm));
        chk(e.tag_flag, W'(cmp_flag_o), W'(e.flag));
        chk("R3", W'(dir_o), W'(e.dir));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: state held at zero while in reset
    chk("R11", cnt_o, '0);
    chk("R11", W'(pwm_o), '0);
    chk("R11", W'(cmp_flag_o), '0);
    chk("R11", W'(dir_o), '0);
    rst_n = 1'b1;
    // R1, R4: up-count, period 8, compare 4
    tick(1, 2'd0, W'(8));
    tick(1, 2'd1, W'(4));
    run_clr(2);
    run(20);
    tick(1, 2'd1, W'(9));   // R6 beyond period
    run(12);
    tick(1, 2'd1, W'(0));   // R7 zero compare
    run_clr(2);
    run(12);
    tick(1, 2'd1, W'(8));   // compare equal to period
    run(12);
    run_clr(20);            // R10 collisions in edge mode
    // R2, R5: down-count
    tick(1, 2'd1, W'(4));
    tick(1, 2'd2, W'(1));
    run(20);
    tick(1, 2'd1, W'(0));   // R5 no zero duty
    run(12);
    tick(1, 2'd1, W'(20));  // R6 in down mode
    run(12);
    // R3, R9: center modes with differing flag slopes
    tick(1, 2'd0, W'(6));
    tick(1, 2'd1, W'(3));
    for (int m = 1; m < 4; m++) begin
      tick(1, 2'd2, W'(m << 1));
      run_clr(30);
      run(15);
      run_clr(1);
      run(15);
      tick(1, 2'd2, W'((m << 1) | 1));  // direction write ignored in center (R3)
      run(15);
    end
    tick(1, 2'd1, W'(7));   // R6 in center mode
    run(20);
    tick(1, 2'd1, W'(0));
    run_clr(2);
    run(20);
    // back to edge up with tiny period
    tick(1, 2'd2, W'(0));
    tick(1, 2'd0, W'(1));
    tick(1, 2'd1, W'(1));
    run_clr(10);
    run(6);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule